// File: doc/BRIEF.md
# Bit-Slice Pattern Match Engine

This block evaluates a programmable sum-of-products over eight channel inputs that have already been synchronized. Eight slices are chained in order. Each slice picks one channel and tests it against one of eight conditions: a level, an edge, an edge remembered since it was armed, a single-cycle event, or a constant. Runs of consecutive slices are ANDed into product terms. A slice flagged as an endpoint closes the current term, and the next slice opens a new one. Slice 7 always closes a term. The overall match is the OR of all terms.

Software sets the block up through three registers: a source-select register, a condition register (which also holds the endpoint flags), and a control register. The control register switches the engine on in place of ordinary per-pin interrupts, gates the event pulse, and returns the live running product at each slice position. While the engine is on, every endpoint slice drives the interrupt line of the same index. A one-clock event pulse marks each rise of the overall match.

Top module: `pm_engine`

## Requirements
- R1: After synchronous reset, all three registers read zero, every interrupt line is low and the event output is low.
- R2: Slice n takes its input from the channel whose index is in source register bits [8+3n+2 : 8+3n]. Source bits 7:0 always read zero.
- R3: Slice n's condition code is in condition register bits [8+3n+2 : 8+3n]. Bits 6:0 are endpoint flags for slices 0 to 6. Bit 7 always reads zero.
- R4: Code 0 is always true and code 6 is always false. Code 4 is true while the selected input is high, and code 5 is true while it is low.
- R5: Codes 1 (rising), 2 (falling) and 3 (either edge) become true on the selected edge. They stay true until the condition register is written or the engine is switched off.
- R6: Code 7 is true for exactly one clock per edge of either polarity on the selected input.
- R7: A product term ANDs the slices after the previous endpoint up to and including its own endpoint, and slice 7 always ends a term. Interrupt line n carries the term of endpoint slice n. The lines of non-endpoint slices stay low.
- R8: While control bit 0 is clear, all interrupt lines and the status bits are low and the event output is not pulsed.
- R9: The control register reads back bits 1:0 as written and bits 23:2 as zero. Bits 31:24 show the registered running product at each slice position, and writes to them have no effect.
- R10: When control bit 1 is set, the event output is high for one clock each time the overall match goes from false to true. When bit 1 is clear, it never pulses.
- R11: Interrupt lines and the event output are registered. They respond one clock after the input change that caused them, and register reads return data one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 source, 1 condition, 2 control |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read target, same encoding as wr_addr |
| rd_data | output | 32 | Registered read data |
| chan_in | input | 8 | Synchronized channel inputs |
| irq_out | output | 8 | Per-endpoint term outputs |
| evt_out | output | 1 | One-clock match event pulse |

## Verification
The hardest state to reach is a remembered edge that must survive after its input has returned to the old level, and that must then be dropped only by a condition write or by switching the engine off. The stimulus arms an edge slice, makes the edge, and then holds the input steady for several cycles, checking that the term stays true. It then clears the remembered edge once by rewriting the condition register and once by toggling the mode bit, and confirms the term falls even though the input has not moved. The next opposite edge is then shown to set the term again.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [2:0] {
    C_ONE  = 3'd0,
    C_RISE = 3'd1,
    C_FALL = 3'd2,
    C_EDGE = 3'd3,
    C_HIGH = 3'd4,
    C_LOW  = 3'd5,
    C_ZERO = 3'd6,
    C_EVT  = 3'd7
  } pm_cond_e;

  localparam logic [1:0] A_SRC = 2'd0;
  localparam logic [1:0] A_CFG = 2'd1;
  localparam logic [1:0] A_CTL = 2'd2;
endpackage

// File: rtl/pm_slice.sv
module pm_slice
  import pm_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int SELW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic [SELW-1:0] sel_i,
  input  pm_cond_e        cond_i,
  input  logic [NCH-1:0]  cur_i,
  input  logic [NCH-1:0]  prv_i,
  output logic            hit_o
);
  logic x, px, rise, fall, edge_hit, seen_q;

  assign x    = cur_i[sel_i];
  assign px   = prv_i[sel_i];
  assign rise = x & ~px;
  assign fall = ~x & px;

  always_comb begin
    case (cond_i)
      C_RISE:  edge_hit = rise;
      C_FALL:  edge_hit = fall;
      C_EDGE:  edge_hit = rise | fall;
      default: edge_hit = 1'b0;
    endcase
  end

  // remembered edge, dropped on condition write or mode off
  always_ff @(posedge clk) begin
    if (rst || clr_i) seen_q <= 1'b0;
    else if (edge_hit) seen_q <= 1'b1;
  end

  always_comb begin
    case (cond_i)
      C_ONE:                 hit_o = 1'b1;
      C_RISE, C_FALL, C_EDGE: hit_o = (seen_q & ~clr_i) | edge_hit;
      C_HIGH:                hit_o = x;
      C_LOW:                 hit_o = ~x;
      C_ZERO:                hit_o = 1'b0;
      default:               hit_o = rise | fall;
    endcase
  end

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !clr_i) |=> seen_q);
endmodule

// File: rtl/pm_chain.sv
module pm_chain #(
  parameter int NSL = 8
) (
  input  logic [NSL-1:0] hit_i,
  input  logic [NSL-1:0] endpt_i,
  output logic [NSL-1:0] acc_o,
  output logic [NSL-1:0] term_o
);
  genvar n;
  generate
    for (n = 0; n < NSL; n++) begin : g_link
      if (n == 0) begin : g_head
        assign acc_o[n] = hit_i[n];
      end else begin : g_body
        assign acc_o[n] = hit_i[n] & (endpt_i[n-1] | acc_o[n-1]);
      end
    end
  endgenerate

  assign term_o = acc_o & endpt_i;
endmodule

// File: rtl/pm_engine.sv
module pm_engine
  import pm_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int NSL   = 8,
  parameter int DW    = 32,
  parameter int FBASE = 8,
  parameter int FW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [NCH-1:0] chan_in,
  output logic [NSL-1:0] irq_out,
  output logic          evt_out
);
  localparam int SELW = $clog2(NCH);
  localparam int NEP  = NSL - 1;
  localparam logic [DW-1:0] SRC_MASK = {{(DW-FBASE){1'b1}}, {FBASE{1'b0}}};
  localparam logic [DW-1:0] CFG_MASK = {{(DW-FBASE){1'b1}}, {(FBASE-NEP){1'b0}}, {NEP{1'b1}}};

  logic [DW-1:0]  src_q, cfg_q;
  logic           pm_on_q, evt_en_q, match_q;
  logic [NCH-1:0] prev_q;
  logic [NSL-1:0] term_q, hit, acc, term, endpt;
  logic           cfg_wr, clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= '0;
      cfg_q    <= '0;
      pm_on_q  <= 1'b0;
      evt_en_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_SRC:   src_q <= wr_data & SRC_MASK;
        A_CFG:   cfg_q <= wr_data & CFG_MASK;
        A_CTL:   {evt_en_q, pm_on_q} <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  assign cfg_wr = wr_en && (wr_addr == A_CFG);
  assign clr    = cfg_wr | ~pm_on_q;
  assign endpt  = {1'b1, cfg_q[NEP-1:0]};

  genvar n;
  generate
    for (n = 0; n < NSL; n++) begin : g_slice
      pm_slice #(.NCH(NCH), .SELW(SELW)) u_slice (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr),
        .sel_i (src_q[FBASE+FW*n +: SELW]),
        .cond_i(pm_cond_e'(cfg_q[FBASE+FW*n +: FW])),
        .cur_i (chan_in),
        .prv_i (prev_q),
        .hit_o (hit[n])
      );
    end
  endgenerate

  pm_chain #(.NSL(NSL)) u_chain (
    .hit_i  (hit),
    .endpt_i(endpt),
    .acc_o  (acc),
    .term_o (term)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      term_q  <= '0;
      irq_out <= '0;
      match_q <= 1'b0;
      evt_out <= 1'b0;
    end else begin
      prev_q  <= chan_in;
      term_q  <= pm_on_q ? acc : '0;
      irq_out <= pm_on_q ? term : '0;
      match_q <= pm_on_q & (|term);
      evt_out <= evt_en_q & pm_on_q & (|term) & ~match_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        A_SRC:   rd_data <= src_q;
        A_CFG:   rd_data <= cfg_q;
        A_CTL:   rd_data <= {term_q, {(DW-NSL-2){1'b0}}, evt_en_q, pm_on_q};
        default: rd_data <= '0;
      endcase
    end
  end

  // R8
  mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    !pm_on_q |=> (irq_out == '0));

  // R7
  nonend_low_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_out & ~$past(endpt)) == '0));

  // R10
  evt_gate_chk: assert property (@(posedge clk) disable iff (rst)
    evt_out |-> ($past(evt_en_q) && match_q));

  // R10
  evt_single_chk: assert property (@(posedge clk) disable iff (rst)
    evt_out |=> !evt_out);
endmodule

// File: tb/pm_engine_test.sv
module pm_engine_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  chan_in = '0;
  logic [7:0]  irq_out;
  logic        evt_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  pm_engine uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .chan_in(chan_in),
    .irq_out(irq_out), .evt_out(evt_out)
  );

  typedef struct packed {
    logic [23:0] sels;
    logic [23:0] conds;
    logic [6:0]  ep;
    logic [7:0]  chan;
    logic [7:0]  expv;
  } vec_t;

  localparam logic [23:0] IDS = 24'o76543210;
  localparam vec_t VT [11] = '{
    '{IDS,          24'o44444444, 7'h7f, 8'hA5, 8'hA5},
    '{IDS,          24'o55555555, 7'h7f, 8'hA5, 8'h5A},
    '{IDS,          24'o44444444, 7'h00, 8'hFF, 8'h80},
    '{IDS,          24'o44444444, 7'h00, 8'hFE, 8'h00},
    '{IDS,          24'o55554444, 7'h08, 8'h0F, 8'h88},
    '{IDS,          24'o55554444, 7'h08, 8'h1F, 8'h08},
    '{IDS,          24'o00000000, 7'h7f, 8'h00, 8'hFF},
    '{IDS,          24'o66666666, 7'h7f, 8'h00, 8'h00},
    '{IDS,          24'o00000006, 7'h03, 8'h00, 8'h82},
    '{24'o33333333, 24'o44444444, 7'h7f, 8'h08, 8'hFF},
    '{24'o33333333, 24'o44444444, 7'h7f, 8'hF7, 8'h00}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    tick(2);
    rd_addr = a;
    tick(1);
    d = rd_data;
  endtask

  task automatic setcfg(input logic [23:0] c, input logic [6:0] ep);
    wr(2'd1, {c, 1'b0, ep});
  endtask

  initial begin
    logic [31:0] r;
    int pulses;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 irq", {24'h0, irq_out}, 32'h0);
    chk("R1 evt", {31'h0, evt_out}, 32'h0);
    rd(2'd0, r); chk("R1 src", r, 32'h0);
    rd(2'd1, r); chk("R1 cfg", r, 32'h0);
    rd(2'd2, r); chk("R1 ctl", r, 32'h0);

    // R4 R7 R2 table walk
    wr(2'd2, 32'h1);
    for (int i = 0; i < 11; i++) begin
      wr(2'd0, {VT[i].sels, 8'h00});
      setcfg(VT[i].conds, VT[i].ep);
      chan_in = VT[i].chan;
      tick(2);
      chk("R4/R7/R2 table", {24'h0, irq_out}, {24'h0, VT[i].expv});
    end

    // R9 running product status
    wr(2'd0, {IDS, 8'h00});
    setcfg(24'o44444444, 7'h00);
    chan_in = 8'h0F;
    tick(2);
    chk("R7 single term", {24'h0, irq_out}, 32'h0);
    rd(2'd2, r); chk("R9 status", r, 32'h0F000001);

    // R5 rising edge memory
    chan_in = 8'h00;
    setcfg(24'o00000001, 7'h00);
    tick(2);
    chk("R5 idle", {24'h0, irq_out}, 32'h0);
    chan_in = 8'h01;
    tick(1);
    chk("R11 R5 rise", {24'h0, irq_out}, 32'h80);
    chan_in = 8'h00;
    tick(4);
    chk("R5 held", {24'h0, irq_out}, 32'h80);
    setcfg(24'o00000001, 7'h00);
    tick(2);
    chk("R5 cfg clears", {24'h0, irq_out}, 32'h0);

    // R5 either edge, cleared by mode off
    setcfg(24'o00000003, 7'h00);
    tick(1);
    chan_in = 8'h01;
    tick(1);
    chk("R5 edge", {24'h0, irq_out}, 32'h80);
    wr(2'd2, 32'h0);
    tick(2);
    chk("R8 off irq", {24'h0, irq_out}, 32'h0);
    rd(2'd2, r); chk("R8 off status", r, 32'h0);
    wr(2'd2, 32'h1);
    tick(2);
    chk("R5 mode clears", {24'h0, irq_out}, 32'h0);
    chan_in = 8'h00;
    tick(1);
    chk("R5 fall side", {24'h0, irq_out}, 32'h80);

    // R6 event condition
    setcfg(24'o00000007, 7'h00);
    tick(2);
    chk("R6 idle", {24'h0, irq_out}, 32'h0);
    chan_in = 8'h01;
    tick(1);
    chk("R6 rise pulse", {24'h0, irq_out}, 32'h80);
    tick(1);
    chk("R6 one cycle", {24'h0, irq_out}, 32'h0);
    chan_in = 8'h00;
    tick(1);
    chk("R6 fall pulse", {24'h0, irq_out}, 32'h80);
    tick(1);
    chk("R6 fall end", {24'h0, irq_out}, 32'h0);

    // R10 event output
    wr(2'd2, 32'h3);
    setcfg(24'o00000004, 7'h00);
    tick(2);
    chk("R10 quiet", {31'h0, evt_out}, 32'h0);
    chan_in = 8'h01;
    tick(1);
    chk("R11 evt latency", {31'h0, evt_out}, 32'h1);
    pulses = 0;
    for (int k = 0; k < 4; k++) begin
      tick(1);
      if (evt_out) pulses++;
    end
    chk("R10 single pulse", pulses, 0);
    chan_in = 8'h00;
    tick(2);
    wr(2'd2, 32'h1);
    tick(1);
    chan_in = 8'h01;
    pulses = 0;
    for (int k = 0; k < 4; k++) begin
      tick(1);
      if (evt_out) pulses++;
    end
    chk("R10 gated", pulses, 0);
    chk("R10 match seen", {24'h0, irq_out}, 32'h80);

    // R2 R3 R9 reserved and read-only bits
    wr(2'd0, 32'hFFFFFFFF);
    rd(2'd0, r); chk("R2 src reserved", r, 32'hFFFFFF00);
    wr(2'd1, 32'hFFFFFFFF);
    rd(2'd1, r); chk("R3 cfg reserved", r, 32'hFFFFFF7F);
    wr(2'd2, 32'hFFFFFFFE);
    rd(2'd2, r); chk("R9 ctl read-only", r, 32'h00000002);

    // R1 reset mid-run
    wr(2'd2, 32'h3);
    setcfg(24'o00000000, 7'h7f);
    tick(2);
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(1);
    chk("R1 rerst irq", {24'h0, irq_out}, 32'h0);
    rd(2'd1, r); chk("R1 rerst cfg", r, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule